// File: doc/BRIEF.md
# CRC-4 Protected Serial Link Checker

This block models both ends of a one-bit serial link. Each end has its own CRC-4 engine, and the generator polynomial is x^4 + x^3 + 1 (binary 11001). An accepted start latches a message of `msg_len` bits. The transmit side then shifts the message onto the channel one bit per cycle, most significant bit first. The receive side shifts each channel bit into its receive register. During this transfer both engines take in the same bit stream, except for the channel bits that the error mask flips.

Next, four zeros are pushed into both engines, which finishes the polynomial division. The transmitter then sends its 4-bit remainder over the channel, most significant bit first. The outcome depends on the mode:
- In compare mode the receiver captures that remainder and compares it with its own remainder.
- In appended mode the receiver keeps a copy of its engine state as it stood at the end of the message. It reloads that copy and feeds the arriving remainder through the engine, as though the remainder had been the message's tail. A final residue of 0000 means a clean transfer.

A one-cycle `done` pulse presents the outcome, and the outcome holds until the next accepted start.

Top module: `crc_link`

## Requirements
- R1: While reset is held low at a clock edge (synchronous, active low), `done`, `crc_ok`, `crc_error` and every bit of `rx_msg` are 0 after that edge.
- R2: The channel carries message bit `msg_len-1` first and bit 0 last. During the transfer, the channel bit for message bit i is `msg_data[i] ^ err_mask[i]`. The mask has no effect on the zero push or on the remainder exchange. The transmit remainder is computed on the unflipped message.
- R3: After `done`, `rx_msg[msg_len-1:0]` equals `(msg_data ^ err_mask)` over those bits, and the bits of `rx_msg` above `msg_len-1` are 0.
- R4: With `mode`=0 (compare), `crc_ok` is 1 exactly when the received remainder equals the transmitted remainder. Each remainder is the message polynomial times x^4, modulo 11001.
- R5: With `mode`=1 (appended), `crc_ok` is 1 exactly when the receive residue is 0000. The residue is the received message followed by the transmitted remainder, modulo 11001. For the same inputs, this gives the same verdict as R4.
- R6: Take the rising edge that accepts a start as edge 0. `done` rises at edge `msg_len`+9 and is high for exactly one cycle.
- R7: `crc_ok` and `crc_error` are never both 1. While `done` is high, exactly one of them is 1. Both go to 0 at the edge that accepts a start, and otherwise keep their values until the next outcome.
- R8: A start is ignored in any of these cases:
  - it arrives while a transfer is in progress;
  - `msg_len` is 0;
  - `msg_len` exceeds MSG_MAX.

  An ignored start changes neither the outputs nor the timing or outcome of a transfer in progress.
- R9: Any error mask with exactly one set bit within the message produces `crc_error` in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a transfer; sampled on a rising edge |
| mode | input | 1 | 0 = compare remainders, 1 = remainder appended, zero-residue check |
| msg_len | input | $clog2(MSG_MAX+1) | Message length in bits, 1..MSG_MAX |
| msg_data | input | MSG_MAX | Message; bit msg_len-1 is sent first |
| err_mask | input | MSG_MAX | Bit i flips message bit i on the channel |
| rx_msg | output | MSG_MAX | Receive register, filled from the channel |
| crc_ok | output | 1 | Transfer judged error-free |
| crc_error | output | 1 | Transfer judged corrupted |
| done | output | 1 | One-cycle pulse when the outcome is valid |

## Verification
The bench sweeps every message of every length up to an 8-bit maximum in both modes. It also sweeps every error mask over one 8-bit message, with the expected verdict taken from a separate long-division model. A design that sent bits in the wrong order, or applied the mask to the transmit side, would misjudge masks whose reversed pattern is a multiple of 11001. A design that forgot to reload the copy register would report failures on clean appended-mode transfers. Further tests pulse start mid-transfer and with lengths of 0 and above the maximum, so a design that restarted or cleared its outcome would break the timing or the held verdict. Counting the `done` latency exposes any off-by-one in the stage counters.

// File: rtl/lnk_pkg.sv
// Package: constants and the stage encoding shared by the link modules.
// Assumes a CRC-4 generator x^4 + x^3 + 1; only the low four bits are stored.
package lnk_pkg;
    localparam int          CRC_W    = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 4'b1001;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_XFER  = 3'd1,
        PH_ZPUSH = 3'd2,
        PH_XCHG  = 3'd3,
        PH_CHECK = 3'd4
    } phase_t;
endpackage

// File: rtl/lnk_crc_eng.sv
// Module: one shift-and-xor CRC division engine.
// Each enabled cycle shifts din into the low end; if the bit leaving the top
// was 1, the generator's low bits are xored in. The state is therefore always
// the bits taken so far modulo the generator. clr has priority; ld replaces
// the base state with ld_val for the current step.
module lnk_crc_eng #(
    parameter int              W    = 4,
    parameter logic [W-1:0]    POLY = 4'b1001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         din,
    output logic [W-1:0] state
);
    logic [W-1:0] base;
    logic [W-1:0] nxt;

    // Select the starting point and form one division step.
    always_comb begin
        base = ld ? ld_val : state;
        nxt  = {base[W-2:0], din} ^ (base[W-1] ? POLY : '0);
    end

    // Hold, clear or advance the remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= '0;
        end else if (en) begin
            state <= nxt;
        end
    end

    // An idle engine must not drift between stages (R2).
    assert_eng_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(state));
endmodule

// File: rtl/lnk_seq.sv
// Module: stage sequencer for the link.
// It walks idle -> transfer (len cycles) -> zero push (CRC_W cycles) ->
// exchange (CRC_W cycles) -> check (1 cycle) -> idle, and raises done for
// one cycle on the return to idle. It assumes go is only raised while idle
// with 1 <= len.
module lnk_seq
    import lnk_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int TAIL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] len,
    output phase_t           phase,
    output logic [LEN_W-1:0] cnt,
    output logic             done
);
    localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
    localparam logic [LEN_W-1:0] TAIL_END = LEN_W'(TAIL - 1);

    // Advance the stage and its bit counter; emit the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase <= PH_XFER;
                        cnt   <= '0;
                    end
                end
                PH_XFER: begin
                    if (cnt == len - ONE) begin
                        phase <= PH_ZPUSH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_ZPUSH: begin
                    if (cnt == TAIL_END) begin
                        phase <= PH_XCHG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_XCHG: begin
                    if (cnt == TAIL_END) begin
                        phase <= PH_CHECK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    // done lasts exactly one cycle (R6).
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // The transfer counter stays inside the message (R6).
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_XFER) |-> (cnt < len));

    // A busy sequencer never restarts the transfer (R8).
    assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> !(phase == PH_XFER && cnt == '0));
endmodule

// File: rtl/crc_link.sv
// Module: top of the CRC-protected serial link model.
// On an accepted start it latches the message, mask, length and mode, then:
// transfer (channel = message bit ^ mask bit, MSB first), zero push into both
// engines, and exchange of the transmit remainder over the channel. In compare
// mode the receiver captures the remainder and compares; in appended mode it
// reloads its end-of-message state and checks for a zero residue.
// Assumes MSG_MAX >= 2.
module crc_link
    import lnk_pkg::*;
#(
    parameter int MSG_MAX = 64,
    localparam int LEN_W  = $clog2(MSG_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode,
    input  logic [LEN_W-1:0]   msg_len,
    input  logic [MSG_MAX-1:0] msg_data,
    input  logic [MSG_MAX-1:0] err_mask,
    output logic [MSG_MAX-1:0] rx_msg,
    output logic               crc_ok,
    output logic               crc_error,
    output logic               done
);
    localparam int SEL_W = $clog2(CRC_W);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MSG_MAX);

    phase_t             phase;
    logic [LEN_W-1:0]   cnt;
    logic               go;
    logic [MSG_MAX-1:0] msg_sh;
    logic [MSG_MAX-1:0] mask_sh;
    logic [LEN_W-1:0]   len_r;
    logic               mode_r;
    logic [CRC_W-1:0]   tx_crc;
    logic [CRC_W-1:0]   rx_crc;
    logic [CRC_W-1:0]   tx_rev;
    logic [CRC_W-1:0]   cpy;
    logic [CRC_W-1:0]   cap;
    logic               tx_bit;
    logic               chan;
    logic               in_xfer;
    logic               in_zpush;
    logic               in_xchg;
    logic               rx_en;
    logic               rx_ld;
    logic               match;

    // Accept a start only while idle and with a legal length.
    assign go = start && (phase == PH_IDLE) && (msg_len != '0) && (msg_len <= LEN_MAX);

    assign in_xfer  = (phase == PH_XFER);
    assign in_zpush = (phase == PH_ZPUSH);
    assign in_xchg  = (phase == PH_XCHG);

    // Bit-reversed view of the transmit remainder, so a counter picks MSB first.
    for (genvar i = 0; i < CRC_W; i++) begin : g_rev
        assign tx_rev[i] = tx_crc[CRC_W-1-i];
    end

    // Choose what the transmitter puts on the channel, then apply the mask.
    always_comb begin
        tx_bit = 1'b0;
        if (in_xfer) begin
            tx_bit = msg_sh[MSG_MAX-1];
        end else if (in_xchg) begin
            tx_bit = tx_rev[cnt[SEL_W-1:0]];
        end
        chan = tx_bit ^ (in_xfer & mask_sh[MSG_MAX-1]);
    end

    // Receive engine runs through the exchange only in appended mode.
    assign rx_en = in_xfer || in_zpush || (in_xchg && mode_r);
    assign rx_ld = in_xchg && mode_r && (cnt == '0);

    lnk_seq #(.LEN_W(LEN_W), .TAIL(CRC_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .len   (len_r),
        .phase (phase),
        .cnt   (cnt),
        .done  (done)
    );

    lnk_crc_eng #(.W(CRC_W), .POLY(CRC_POLY)) u_tx_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .en     (in_xfer || in_zpush),
        .ld     (1'b0),
        .ld_val ('0),
        .din    (tx_bit),
        .state  (tx_crc)
    );

    lnk_crc_eng #(.W(CRC_W), .POLY(CRC_POLY)) u_rx_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .en     (rx_en),
        .ld     (rx_ld),
        .ld_val (cpy),
        .din    (chan),
        .state  (rx_crc)
    );

    // Latch the request, left-aligning message and mask so the top bit goes first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_sh  <= '0;
            mask_sh <= '0;
            len_r   <= '0;
            mode_r  <= 1'b0;
        end else if (go) begin
            msg_sh  <= msg_data << (LEN_MAX - msg_len);
            mask_sh <= err_mask << (LEN_MAX - msg_len);
            len_r   <= msg_len;
            mode_r  <= mode;
        end else if (in_xfer) begin
            msg_sh  <= msg_sh << 1;
            mask_sh <= mask_sh << 1;
        end
    end

    // Receive register: shift in channel bits during the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            rx_msg <= '0;
        end else if (in_xfer) begin
            rx_msg <= {rx_msg[MSG_MAX-2:0], chan};
        end
    end

    // Copy the end-of-message receive state; capture the remainder in compare mode.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            cpy <= '0;
            cap <= '0;
        end else begin
            if (in_zpush && cnt == '0) begin
                cpy <= rx_crc;
            end
            if (in_xchg && !mode_r) begin
                cap <= {cap[CRC_W-2:0], chan};
            end
        end
    end

    assign match = mode_r ? (rx_crc == '0) : (cap == rx_crc);

    // Publish the verdict at the check stage; clear it on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            crc_ok    <= 1'b0;
            crc_error <= 1'b0;
        end else if (phase == PH_CHECK) begin
            crc_ok    <= match;
            crc_error <= !match;
        end
    end

    // Verdict flags are exclusive at all times (R7).
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_error));

    // A done pulse always carries a verdict (R7).
    assert_done_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (crc_ok != crc_error));

    // With no start accepted while idle, the verdict holds (R7).
    assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !go) |=> ($stable(crc_ok) && $stable(crc_error)));

    // The latched request is frozen while a transfer runs (R8).
    assert_req_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(len_r) && $stable(mode_r)));

    // The receive register only moves during a transfer or on a new start (R3).
    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_xfer && !go) |=> $stable(rx_msg));
endmodule

// File: tb/tb_crc_link.sv
// Bench: sweeps all messages up to 8 bits and all masks over one message,
// against a long-division model of CRC-4 with generator 11001.
module tb_crc_link;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 8;
    localparam int LW         = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic            mode;
    logic [LW-1:0]   msg_len;
    logic [MAXB-1:0] msg_data;
    logic [MAXB-1:0] err_mask;
    logic [MAXB-1:0] rx_msg;
    logic            crc_ok;
    logic            crc_error;
    logic            done;

    int n_chk  = 0;
    int n_fail = 0;
    int lat;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_link #(.MSG_MAX(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .msg_len(msg_len), .msg_data(msg_data), .err_mask(err_mask),
        .rx_msg(rx_msg), .crc_ok(crc_ok), .crc_error(crc_error), .done(done)
    );

    // Remainder of (value * x^4) modulo 11001, by bitwise long division.
    function automatic logic [3:0] ref_rem(input logic [MAXB-1:0] v, input int len);
        logic [3:0] r = 4'b0000;
        for (int i = len - 1; i >= 0; i--) begin
            logic fb = r[3] ^ v[i];
            r = {r[2:0], 1'b0} ^ (fb ? 4'b1001 : 4'b0000);
        end
        return r;
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one transfer, wait for done, and check all outputs.
    task automatic run(input bit md, input int len, input logic [MAXB-1:0] m,
                       input logic [MAXB-1:0] k, input string vreq);
        logic [MAXB-1:0] lowm;
        bit exp_ok;
        lowm   = MAXB'((1 << len) - 1);
        exp_ok = (ref_rem(m, len) == ref_rem(m ^ k, len));
        @(negedge clk);
        mode = md; msg_len = LW'(len); msg_data = m; err_mask = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check(!crc_ok && !crc_error, "R7", "flags cleared at start", int'(crc_ok), 0);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == len + 10, "R6", "done latency", lat, len + 10);
        check(crc_ok != crc_error, "R7", "one verdict flag", int'(crc_ok), int'(!crc_error));
        check(crc_ok == exp_ok, vreq, "verdict", int'(crc_ok), int'(exp_ok));
        if ($countones(k & lowm) == 1)
            check(crc_error, "R9", "single-bit error flagged", int'(crc_error), 1);
        check(rx_msg == ((m ^ k) & lowm), "R3", "received message", int'(rx_msg),
              int'((m ^ k) & lowm));
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [MAXB-1:0] held;
        rst_n = 1'b0; start = 1'b1; mode = 1'b0;
        msg_len = LW'(4); msg_data = '1; err_mask = '0;
        repeat (3) @(negedge clk);
        check(!done && !crc_ok && !crc_error && rx_msg == '0, "R1",
              "outputs in reset", int'(rx_msg), 0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !crc_ok && !crc_error, "R1", "outputs after reset", int'(done), 0);

        // Clean transfers: every message of every length, both modes (R4, R5).
        for (int md = 0; md < 2; md++)
            for (int len = 1; len <= MAXB; len++)
                for (int m = 0; m < (1 << len); m++)
                    run(md[0], len, MAXB'(m), '0, md == 0 ? "R4" : "R5");

        // All masks over one message: order and mask placement matter (R2).
        for (int md = 0; md < 2; md++)
            for (int k = 1; k < 256; k++)
                run(md[0], MAXB, 8'h6B, MAXB'(k), "R2");

        // Shorter message with masks reaching above its length (R2, R3).
        for (int k = 1; k < 64; k++)
            run(k[0], 5, 8'h13, MAXB'(k), "R2");

        // Verdict holds while idle (R7).
        run(1'b0, 6, 8'h2D, 8'h04, "R4");
        repeat (5) @(negedge clk);
        check(crc_error && !crc_ok, "R7", "verdict held", int'(crc_error), 1);

        // Start pulsed mid-transfer is ignored (R8).
        run(1'b1, 7, 8'h55, '0, "R5");
        @(negedge clk);
        mode = 1'b0; msg_len = LW'(8); msg_data = 8'hA5; err_mask = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        mode = 1'b1; msg_len = LW'(2); msg_data = 8'h03; err_mask = 8'h01; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 18, "R8", "latency unchanged by busy start", lat, 18);
        check(crc_ok && !crc_error, "R8", "verdict unchanged by busy start", int'(crc_ok), 1);
        check(rx_msg == 8'hA5, "R8", "message unchanged by busy start", int'(rx_msg), 165);

        // Illegal lengths 0 and MAXB+1 are ignored (R8).
        held = rx_msg;
        for (int bad = 0; bad < 2; bad++) begin
            int seen = 0;
            @(negedge clk);
            msg_len = (bad == 0) ? LW'(0) : LW'(MAXB + 1);
            msg_data = 8'hFF; err_mask = 8'hFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(crc_ok && !crc_error, "R8", "verdict kept on bad length", int'(crc_ok), 1);
            repeat (25) begin
                @(negedge clk);
                if (done) seen++;
            end
            check(seen == 0, "R8", "no done on bad length", seen, 0);
            check(rx_msg == held, "R8", "rx_msg kept on bad length", int'(rx_msg), int'(held));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule